// File: doc/BRIEF.md
# PRBS7 Built-In Self-Test Generator and Checker

This block sits between a protocol-side parallel bus and a 10-bit serializer/deserializer datapath and provides a pattern-based self test. When test mode is off, the transmit word passes through untouched. When test mode is on, the transmit word is replaced by consecutive 10-bit slices of a 127-bit pseudorandom sequence. In the same mode, every received word that carries a valid strobe is checked against a local copy of that sequence.

The receive checker locks on its own. It takes its starting state from the first seven bits it receives after test mode is entered. From then on it predicts every later bit and compares each one with what arrives. A single pass flag reports the result. With the report-mode input low, the flag follows the verdict on the most recent valid word. With it high, the first mismatch pulls the flag low and holds it there. The hold is released when the report mode or the test enable changes.

Top module: `prbs7_bist`

## Requirements
- R1: During and right after reset, pass_o is 1 and the generator sits at its all-ones starting state.
- R2: While test_en_i is 0, tx_word_o equals tx_word_i in the same cycle.
- R3: While test_en_i is 1, tx_word_o carries sequence bits s[10k]..s[10k+9] in the k-th cycle of the test session, with s[10k] on bit 0. The sequence follows s[n] = s[n-7] xor s[n-6], and the seven bits before s[0] are all 1. tx_word_i has no effect.
- R4: The generated sequence repeats every 127 bits, so the word in session cycle 127 equals the word in session cycle 0.
- R5: Leaving test mode and entering it again restarts the generator from the all-ones state.
- R6: In the first valid word of a test session, bits 0 to 6 load the checker and are not judged, and bits 7 to 9 are compared. Every bit of each later valid word is compared against the prediction. Any phase of the received sequence is accepted.
- R7: pass_o changes only in the cycle after a valid word, or in the cycle after a change of test_en_i or latch_mode_i. Cycles with rx_valid_i at 0 leave it unchanged.
- R8: With latch_mode_i at 0, pass_o after a valid word is 1 if that word fully matched and 0 otherwise.
- R9: With latch_mode_i at 1, one mismatching word drives pass_o to 0, and it stays 0 while latch_mode_i and test_en_i stay constant. Any change of latch_mode_i restarts the judgement from 1. A valid word in that same cycle is judged against the fresh start.
- R10: pass_o is 1 in every cycle that follows a cycle with test_en_i at 0, whatever arrives on rx_word_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_en_i | input | 1 | Enables the generator and the checker |
| latch_mode_i | input | 1 | 0 reports live, 1 makes the first error stick |
| tx_word_i | input | 10 | Normal transmit word |
| rx_word_i | input | 10 | Received word, bit 0 earliest |
| rx_valid_i | input | 1 | Marks rx_word_i as valid |
| tx_word_o | output | 10 | Word handed to the serializer |
| pass_o | output | 1 | Check result, 1 means pass |

## Verification
Two events can land in the same cycle: a toggle of the report mode and the arrival of a corrupted valid word. The bench provokes this by raising latch_mode_i in exactly the cycle it presents a word with one flipped bit. It expects pass_o to be low in the following cycle, because the clear and the new error are judged together and the error wins. A second overlap also gets its own case: the first word of a session is both seed and check, and a flip in bits 7 to 9 of that word must already pull the flag low.

// File: rtl/prbs7_pkg.sv
package prbs7_pkg;
  localparam int LFSR_W = 7;
  localparam int TAP_HI = 7;
  localparam int TAP_LO = 6;
  typedef logic [LFSR_W-1:0] lfsr_t;
  localparam lfsr_t SEED = '1;

  // state[0] holds the newest bit
  function automatic logic next_bit(lfsr_t s);
    return s[TAP_HI-1] ^ s[TAP_LO-1];
  endfunction
endpackage

// File: rtl/prbs7_gen.sv
module prbs7_gen
  import prbs7_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic [WORD_W-1:0] word_o
);
  lfsr_t state_q, state_nxt;

  always_comb begin
    lfsr_t s;
    logic  b;
    s = state_q;
    word_o = '0;
    for (int i = 0; i < WORD_W; i++) begin
      b = next_bit(s);
      word_o[i] = b;
      s = {s[LFSR_W-2:0], b};
    end
    state_nxt = s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= SEED;
    else if (!en_i) state_q <= SEED;
    else            state_q <= state_nxt;
  end

  // R3
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

// File: rtl/prbs7_chk.sv
module prbs7_chk
  import prbs7_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              err_o
);
  lfsr_t             pred_q, pred_nxt;
  logic              seeded_q;
  logic [WORD_W-1:0] mism;

  always_comb begin
    lfsr_t s;
    logic  b;
    s = pred_q;
    mism = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (!seeded_q && i < LFSR_W) begin
        s = {s[LFSR_W-2:0], word_i[i]};
      end else begin
        b = next_bit(s);
        mism[i] = b ^ word_i[i];
        s = {s[LFSR_W-2:0], b};
      end
    end
    pred_nxt = s;
  end

  assign err_o = en_i & valid_i & (|mism);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seeded_q <= 1'b0;
      pred_q   <= '0;
    end else if (!en_i) begin
      seeded_q <= 1'b0;
    end else if (valid_i) begin
      seeded_q <= 1'b1;
      pred_q   <= pred_nxt;
    end
  end

  // R6
  seed_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!en_i) |-> !seeded_q);
endmodule

// File: rtl/prbs7_pass.sv
module prbs7_pass (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic latch_i,
  input  logic valid_i,
  input  logic err_i,
  output logic pass_o
);
  logic mode_q, pass_q, clear, base;

  assign clear  = !en_i || (latch_i != mode_q);
  assign base   = (clear || !latch_i) ? 1'b1 : pass_q;
  assign pass_o = pass_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      pass_q <= 1'b1;
    end else begin
      mode_q <= latch_i;
      if (en_i && valid_i) pass_q <= base & ~err_i;
      else if (clear)      pass_q <= 1'b1;
    end
  end

  // R9
  sticky_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && latch_i && mode_q && !pass_q) |=> !pass_q);
endmodule

// File: rtl/prbs7_bist.sv
module prbs7_bist #(
  parameter int WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_en_i,
  input  logic              latch_mode_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic              rx_valid_i,
  output logic [WORD_W-1:0] tx_word_o,
  output logic              pass_o
);
  logic [WORD_W-1:0] gen_word;
  logic              word_err;

  prbs7_gen #(.WORD_W(WORD_W)) u_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (test_en_i),
    .word_o (gen_word)
  );

  prbs7_chk #(.WORD_W(WORD_W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (test_en_i),
    .valid_i (rx_valid_i),
    .word_i  (rx_word_i),
    .err_o   (word_err)
  );

  prbs7_pass u_pass (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (test_en_i),
    .latch_i (latch_mode_i),
    .valid_i (rx_valid_i),
    .err_i   (word_err),
    .pass_o  (pass_o)
  );

  assign tx_word_o = test_en_i ? gen_word : tx_word_i;

  // R8
  live_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_en_i && !latch_mode_i && rx_valid_i && !word_err) |=> pass_o);

  // R8
  err_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_en_i && rx_valid_i && word_err) |=> !pass_o);

  // R10
  idle_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_en_i |=> pass_o);
endmodule

// File: tb/prbs7_bist_test.sv
`timescale 1ns/1ps
module prbs7_bist_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       test_en = 1'b0, latch_mode = 1'b0, rx_valid = 1'b0;
  logic [9:0] tx_in = '0, rx_in = '0;
  logic [9:0] tx_out;
  logic       pass;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  bit arr [0:3999];
  int gen_idx = 0;
  logic pass_m = 1'b1, mode_prev_m = 1'b0;

  logic [9:0] txq [$];
  logic       pq  [$];
  string      tagq[$];

  always #2 clk = ~clk;

  prbs7_bist uut (
    .clk_i(clk), .rst_ni(rst_n), .test_en_i(test_en), .latch_mode_i(latch_mode),
    .tx_word_i(tx_in), .rx_word_i(rx_in), .rx_valid_i(rx_valid),
    .tx_word_o(tx_out), .pass_o(pass)
  );

  function automatic logic [9:0] seg(int p);
    logic [9:0] w;
    for (int i = 0; i < 10; i++) w[i] = arr[p+i];
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, push expectations
  task automatic cyc(input logic en, input logic md, input logic [9:0] txw,
                     input logic vld, input logic [9:0] rxw, input logic bad, input string tag);
    logic clr, base;
    @(posedge clk); #1;
    test_en = en; latch_mode = md; tx_in = txw; rx_valid = vld; rx_in = rxw;
    txq.push_back(en ? seg(7 + 10*gen_idx) : txw);
    pq.push_back(pass_m);
    tagq.push_back(tag);
    gen_idx = en ? gen_idx + 1 : 0;
    clr = !en || (md != mode_prev_m);
    if (en && vld) begin
      base = (clr || !md) ? 1'b1 : pass_m;
      pass_m = base & ~bad;
    end else if (clr) pass_m = 1'b1;
    mode_prev_m = md;
  endtask

  // monitor
  always @(negedge clk) begin
    if (txq.size() > 0) begin
      logic [9:0] et;
      logic ep;
      string t;
      et = txq.pop_front(); ep = pq.pop_front(); t = tagq.pop_front();
      check(tx_out === et, {t, " tx"}, tx_out, et);
      check(pass === ep, {t, " pass"}, {9'd0, pass}, {9'd0, ep});
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [9:0] first_w;
    int rp;
    for (int n = 0; n < 4000; n++) arr[n] = (n < 7) ? 1'b1 : (arr[n-7] ^ arr[n-6]);

    // R1 reset state
    repeat (3) @(negedge clk);
    check(pass === 1'b1, "R1 reset pass", {9'd0, pass}, 10'd1);
    test_en = 1'b1; #0.5;
    check(tx_out === seg(7), "R1 seed word", tx_out, seg(7));
    test_en = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;

    // R2 passthrough
    cyc(0, 0, 10'h3FF, 0, 0, 0, "R2");
    cyc(0, 0, 10'h000, 0, 0, 0, "R2");
    cyc(0, 0, 10'h2AA, 0, 0, 0, "R2");
    cyc(0, 0, 10'h155, 1, 10'h3C1, 0, "R2");
    for (int k = 0; k < 4; k++) cyc(0, 0, 10'((k * 97) ^ 10'h1B3), 0, 0, 0, "R2");

    // R3 generated words, R4 period
    for (int j = 0; j < 140; j++) begin
      cyc(1, 0, 10'(j * 13), 0, 0, 0, "R3");
      #1;
      if (j == 0) first_w = tx_out;
      if (j == 127) check(tx_out === first_w, "R4 period", tx_out, first_w);
    end

    // R6 R7 R8 live checking, phase offset 3
    rp = 10;
    for (int j = 0; j < 21; j++) begin
      if (j % 3 == 2) cyc(1, 0, 0, 0, 10'h3FF, 0, "R7 idle");
      else if (j == 10) begin
        cyc(1, 0, 0, 1, seg(rp) ^ 10'h010, 1, "R8 bad"); rp += 10;
      end else begin
        cyc(1, 0, 0, 1, seg(rp), 0, "R8 good"); rp += 10;
      end
    end

    // R9 latched
    cyc(1, 1, 0, 1, seg(rp), 0, "R9 enter"); rp += 10;
    cyc(1, 1, 0, 1, seg(rp) ^ 10'h200, 1, "R9 bad"); rp += 10;
    for (int j = 0; j < 5; j++) begin
      cyc(1, 1, 0, 1, seg(rp), 0, "R9 sticky"); rp += 10;
    end
    cyc(1, 1, 0, 0, 0, 0, "R7 hold");
    cyc(1, 0, 0, 1, seg(rp), 0, "R9 release"); rp += 10;
    cyc(1, 0, 0, 0, 0, 0, "R9 release");
    // mode change and error in one cycle
    cyc(1, 1, 0, 1, seg(rp) ^ 10'h001, 1, "R9 same cycle"); rp += 10;
    cyc(1, 1, 0, 0, 0, 0, "R9 same cycle");
    cyc(1, 1, 0, 1, seg(rp), 0, "R9 sticky"); rp += 10;

    // R10 exit test mode
    cyc(0, 1, 10'h0F0, 1, 10'h3FF, 0, "R10");
    cyc(0, 1, 10'h00F, 1, 10'h000, 0, "R10");
    cyc(0, 1, 10'h111, 0, 0, 0, "R10");

    // R5 re-entry, R6 error in bits 7..9 of first word
    rp = 57;
    cyc(1, 0, 10'h2F0, 1, seg(rp) ^ 10'h100, 1, "R6 seed window"); rp += 10;
    cyc(1, 0, 10'h2F0, 1, seg(rp), 0, "R5 restart"); rp += 10;
    cyc(1, 0, 10'h2F0, 1, seg(rp), 0, "R5 restart"); rp += 10;
    cyc(0, 0, 10'h044, 0, 0, 0, "R10");
    cyc(0, 0, 10'h088, 0, 0, 0, "R10");
    rp = 106;
    for (int j = 0; j < 6; j++) begin
      cyc(1, 0, 10'h3A5, 1, seg(rp), 0, "R6 any phase"); rp += 10;
    end
    cyc(0, 0, 0, 0, 0, 0, "R2");

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule